// File: doc/BRIEF.md
# Cyclopean Dynamic Programming Cost Array

This block runs the forward pass of a symmetric dynamic-programming stereo matcher over one rectified scan line. Left and right pixels arrive together. Each new pixel pair opens two Cyclopean columns at twice the image resolution. The block updates the path cost for every disparity 0..DMAX in three visibility states: right-only visible (MR), seen by both cameras (B) and left-only visible (ML). For every updated state it reports which state the winning predecessor was in, as a 2-bit code. A later backtracking stage stores these codes and walks them.

Column x = 2k − DMAX is the first to use pixel k; for it to be even, DMAX must be even. The even column, which updates the even disparities, is computed in the first cycle after the pixel is taken. The odd column is computed in the next cycle. Pixels therefore arrive at most every second cycle, and a `pix_valid` raised during an even-phase cycle is not taken. One register per disparity and state holds the newest column of that disparity's parity. Together these registers make up the two most recent columns.

The left pixels sit in a short window of DMAX/2+1 taps. The right pixels pass a DMAX/2 delay first and are then tapped over DMAX/2+1 positions. Each disparity lane reads fixed taps. The occlusion penalty comes from a port that is held steady during a line. Costs saturate instead of wrapping.

Top module: `cyc_dp_cost`

## Requirements
- R1: After reset, `out_valid` is 0 and every bit of `out_cost` and `out_pred` is 0.
- R2: When a pixel with index k ≥ DMAX/2 is taken at a rising edge, the next edge registers the result for column x = 2k − DMAX (`out_odd`=0), and the edge after that registers the result for x+1 (`out_odd`=1). `out_valid` is high in both cycles that follow those edges.
- R3: The binocular cost of lane d in column x is |L[(x+d)/2] − R[(x−d)/2]| + min(B(x−2,d), MR(x−2,d), ML(x−1,d−1)). Columns before x=0 count as cost 0. Lane d, state s (MR=0, B=1, ML=2) is read at `out_cost[(3d+s)*COST_W +: COST_W]`.
- R4: The left-only cost is min(ML(x−1,d−1), B(x−2,d)) + `occ_pen`.
- R5: The right-only cost is min(MR(x−1,d+1), B(x−1,d+1)) + `occ_pen`.
- R6: A neighbour with a disparity outside 0..DMAX counts as maximum cost. A binocular state with x < d has maximum cost and predecessor code 3.
- R7: A cost sum that exceeds 2^COST_W−1 is held at 2^COST_W−1.
- R8: Equal candidates resolve to B first, then MR, then ML.
- R9: The predecessor code of lane d, state s is at `out_pred[(3d+s)*2 +: 2]`, with 0=MR, 1=B, 2=ML, 3=none.
- R10: In a result cycle, the cost and predecessor fields of lanes whose parity differs from `out_odd` keep their previous values.
- R11: `line_start` clears all costs to 0, cancels any column still being computed and restarts pixel indexing at 0.
- R12: The first DMAX/2 pixels of a line produce no result cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Compute clock, at least twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Pulse that begins a new scan line |
| pix_valid | input | 1 | A left/right pixel pair is presented |
| pix_l | input | PIX_W | Left pixel intensity |
| pix_r | input | PIX_W | Right pixel intensity |
| occ_pen | input | COST_W | Occlusion penalty added to monocular states |
| out_valid | output | 1 | A column result was registered in the last edge |
| out_odd | output | 1 | Parity of the reported column and of its updated lanes |
| out_col | output | POS_W+1 | Cyclopean column index of the result |
| out_pred | output | (DMAX+1)*6 | Predecessor codes, 2 bits per lane and state |
| out_cost | output | (DMAX+1)*3*COST_W | Current cost of every lane and state |

## Verification
The bench models the recurrences on a full column-by-disparity array and compares every updated lane against it. It also compares the held lanes against the model's previous column. A design that used a just-written same-column value instead of the x−1 value would disagree on the odd lanes. The leftmost columns have blocked binocular lanes and missing neighbours at disparities 0 and DMAX. Indexing the pixel taps wrongly or treating a missing neighbour as zero shows up there as a wrong cost or code.

A flat line produces exact ties; a design with the wrong priority reports MR instead of B. A large penalty forces sums past the top of the range; a wrapping adder then reports a small cost. A `line_start` in mid-line must zero the costs and restart the column index; a design that kept the old state would report stale costs on the next line.

// File: rtl/cyc_dp_pkg.sv
package cyc_dp_pkg;

  // Predecessor codes carried on out_pred
  typedef enum logic [1:0] {
    VIS_MR   = 2'b00,
    VIS_B    = 2'b01,
    VIS_ML   = 2'b10,
    VIS_NONE = 2'b11
  } vis_e;

  // Field order of the three states inside a lane
  localparam int NSTATE = 3;
  localparam int SI_MR  = 0;
  localparam int SI_B   = 1;
  localparam int SI_ML  = 2;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'b00,
    SQ_EVEN = 2'b01,
    SQ_ODD  = 2'b10
  } seq_e;

endpackage

// File: rtl/cyc_dp_window.sv
module cyc_dp_window #(
  parameter int DMAX  = 4,
  parameter int PIX_W = 8,
  localparam int L_DEPTH = DMAX/2 + 1,
  localparam int R_DEPTH = DMAX + 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           shift_en,
  input  logic [PIX_W-1:0]               pix_l,
  input  logic [PIX_W-1:0]               pix_r,
  output logic [L_DEPTH-1:0][PIX_W-1:0]  win_l,
  output logic [R_DEPTH-1:0][PIX_W-1:0]  win_r
);

  logic [L_DEPTH-1:0][PIX_W-1:0] l_nxt;
  logic [R_DEPTH-1:0][PIX_W-1:0] r_nxt;

  // Tap 0 is the newest pixel; right taps below DMAX/2 form the delay line
  always_comb begin
    l_nxt = win_l;
    r_nxt = win_r;
    if (shift_en) begin
      l_nxt[0] = pix_l;
      r_nxt[0] = pix_r;
      for (int j = 1; j < L_DEPTH; j++) l_nxt[j] = win_l[j-1];
      for (int j = 1; j < R_DEPTH; j++) r_nxt[j] = win_r[j-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_l <= '0;
      win_r <= '0;
    end else begin
      win_l <= l_nxt;
      win_r <= r_nxt;
    end
  end

endmodule

// File: rtl/cyc_dp_seq.sv
module cyc_dp_seq
  import cyc_dp_pkg::*;
#(
  parameter int DMAX  = 4,
  parameter int POS_W = 12,
  localparam int COL_W = POS_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             pix_valid,
  output logic             accept,
  output logic             calc_en,
  output logic             calc_odd,
  output logic [COL_W-1:0] col_now
);

  seq_e             state_q, state_d;
  logic [POS_W-1:0] cnt_q, cnt_d;
  logic [POS_W-1:0] k_idx;

  assign accept   = pix_valid && !line_start && (state_q != SQ_EVEN);
  assign calc_en  = (state_q != SQ_IDLE);
  assign calc_odd = (state_q == SQ_ODD);
  assign k_idx    = cnt_q - POS_W'(1);
  assign col_now  = {k_idx, calc_odd} - COL_W'(DMAX);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (line_start) begin
      state_d = SQ_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        SQ_EVEN: state_d = SQ_ODD;
        default: begin
          state_d = SQ_IDLE;
          if (accept) begin
            cnt_d = cnt_q + POS_W'(1);
            if (cnt_q >= POS_W'(DMAX/2)) state_d = SQ_EVEN;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/cyc_dp_cell.sv
module cyc_dp_cell
  import cyc_dp_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COST_W = 10
) (
  input  logic [PIX_W-1:0]  pl,
  input  logic [PIX_W-1:0]  pr,
  input  logic [COST_W-1:0] c_b,
  input  logic [COST_W-1:0] c_mr,
  input  logic [COST_W-1:0] c_ml_lo,
  input  logic [COST_W-1:0] c_b_hi,
  input  logic [COST_W-1:0] c_mr_hi,
  input  logic [COST_W-1:0] occ,
  input  logic              b_blocked,
  output logic [COST_W-1:0] n_b,
  output logic [COST_W-1:0] n_mr,
  output logic [COST_W-1:0] n_ml,
  output logic [1:0]        p_b,
  output logic [1:0]        p_mr,
  output logic [1:0]        p_ml
);

  localparam logic [COST_W-1:0] CMAX = {COST_W{1'b1}};

  function automatic logic [COST_W-1:0] sat_add(input logic [COST_W-1:0] a,
                                                 input logic [COST_W-1:0] b);
    logic [COST_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[COST_W] ? CMAX : s[COST_W-1:0];
  endfunction

  logic [PIX_W-1:0]  diff;
  logic [COST_W-1:0] best_b, best_ml, best_mr;
  logic [1:0]        sel_b, sel_ml, sel_mr;

  always_comb begin
    diff = (pl > pr) ? (pl - pr) : (pr - pl);

    // Binocular: B, then MR, then ML on ties
    best_b = c_b;
    sel_b  = VIS_B;
    if (c_mr < best_b)    begin best_b = c_mr;    sel_b = VIS_MR; end
    if (c_ml_lo < best_b) begin best_b = c_ml_lo; sel_b = VIS_ML; end

    best_ml = c_b;
    sel_ml  = VIS_B;
    if (c_ml_lo < best_ml) begin best_ml = c_ml_lo; sel_ml = VIS_ML; end

    best_mr = c_b_hi;
    sel_mr  = VIS_B;
    if (c_mr_hi < best_mr) begin best_mr = c_mr_hi; sel_mr = VIS_MR; end

    n_b  = b_blocked ? CMAX : sat_add(best_b, COST_W'(diff));
    p_b  = b_blocked ? VIS_NONE : sel_b;
    n_ml = sat_add(best_ml, occ);
    p_ml = sel_ml;
    n_mr = sat_add(best_mr, occ);
    p_mr = sel_mr;
  end

endmodule

// File: rtl/cyc_dp_cost.sv
module cyc_dp_cost
  import cyc_dp_pkg::*;
#(
  parameter int DMAX   = 4,
  parameter int PIX_W  = 8,
  parameter int COST_W = 10,
  parameter int POS_W  = 12,
  localparam int LANES   = DMAX + 1,
  localparam int L_DEPTH = DMAX/2 + 1,
  localparam int R_DEPTH = DMAX + 1,
  localparam int COL_W   = POS_W + 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           line_start,
  input  logic                           pix_valid,
  input  logic [PIX_W-1:0]               pix_l,
  input  logic [PIX_W-1:0]               pix_r,
  input  logic [COST_W-1:0]              occ_pen,
  output logic                           out_valid,
  output logic                           out_odd,
  output logic [COL_W-1:0]               out_col,
  output logic [LANES*NSTATE*2-1:0]      out_pred,
  output logic [LANES*NSTATE*COST_W-1:0] out_cost
);

  localparam logic [COST_W-1:0] CMAX = {COST_W{1'b1}};

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  logic             accept, calc_en, calc_odd;
  logic [COL_W-1:0] col_now;
  logic [L_DEPTH-1:0][PIX_W-1:0] win_l;
  logic [R_DEPTH-1:0][PIX_W-1:0] win_r;

  cyc_dp_seq #(.DMAX(DMAX), .POS_W(POS_W)) u_seq (
    .clk(clk), .rst_n(rst_i), .line_start(line_start), .pix_valid(pix_valid),
    .accept(accept), .calc_en(calc_en), .calc_odd(calc_odd), .col_now(col_now)
  );

  cyc_dp_window #(.DMAX(DMAX), .PIX_W(PIX_W)) u_win (
    .clk(clk), .rst_n(rst_i), .shift_en(accept), .pix_l(pix_l), .pix_r(pix_r),
    .win_l(win_l), .win_r(win_r)
  );

  // Lane d holds the newest column of d's parity: x-2 for its own phase, x-1 for the other
  logic [LANES-1:0][NSTATE-1:0][COST_W-1:0] cost_q, cost_d, n_cost;
  logic [LANES-1:0][NSTATE-1:0][1:0]        pred_q, pred_d, n_pred;
  logic [LANES-1:0]                         upd;
  logic             valid_q;
  logic             odd_q;
  logic [COL_W-1:0] col_q;

  for (genvar d = 0; d < LANES; d++) begin : g_lane
    localparam int  JL       = DMAX/2 - (d + 1)/2;
    localparam int  JR       = DMAX/2 + d/2;
    localparam bit  ODD_LANE = (d % 2) == 1;

    logic [COST_W-1:0] ml_lo, b_hi, mr_hi;
    logic              blocked;

    if (d == 0) begin : g_lo_edge
      assign ml_lo   = CMAX;
      assign blocked = 1'b0;
    end else begin : g_lo_in
      assign ml_lo   = cost_q[d-1][SI_ML];
      assign blocked = (col_now < COL_W'(d));
    end

    if (d == DMAX) begin : g_hi_edge
      assign b_hi  = CMAX;
      assign mr_hi = CMAX;
    end else begin : g_hi_in
      assign b_hi  = cost_q[d+1][SI_B];
      assign mr_hi = cost_q[d+1][SI_MR];
    end

    assign upd[d] = calc_en && !line_start && (calc_odd == ODD_LANE);

    cyc_dp_cell #(.PIX_W(PIX_W), .COST_W(COST_W)) u_cell (
      .pl(win_l[JL]), .pr(win_r[JR]),
      .c_b(cost_q[d][SI_B]), .c_mr(cost_q[d][SI_MR]), .c_ml_lo(ml_lo),
      .c_b_hi(b_hi), .c_mr_hi(mr_hi), .occ(occ_pen), .b_blocked(blocked),
      .n_b(n_cost[d][SI_B]), .n_mr(n_cost[d][SI_MR]), .n_ml(n_cost[d][SI_ML]),
      .p_b(n_pred[d][SI_B]), .p_mr(n_pred[d][SI_MR]), .p_ml(n_pred[d][SI_ML])
    );

    AST_HOLD_OTHER: assert property (@(posedge clk) disable iff (!rst_i)
      (out_valid && (out_odd != ODD_LANE)) |-> ($stable(cost_q[d]) && $stable(pred_q[d]))); // R10

    if (d > 0) begin : g_chk_block
      AST_BLOCKED_B: assert property (@(posedge clk) disable iff (!rst_i)
        (out_valid && (out_odd == ODD_LANE) && (out_col < COL_W'(d)))
          |-> (pred_q[d][SI_B] == VIS_NONE && cost_q[d][SI_B] == CMAX)); // R6
    end

    AST_ML_FLOOR: assert property (@(posedge clk) disable iff (!rst_i)
      (out_valid && (out_odd == ODD_LANE)) |-> (cost_q[d][SI_ML] >= $past(occ_pen))); // R7
  end

  always_comb begin
    cost_d = cost_q;
    pred_d = pred_q;
    if (line_start) begin
      cost_d = '0;
    end else begin
      for (int i = 0; i < LANES; i++) begin
        if (upd[i]) begin
          cost_d[i] = n_cost[i];
          pred_d[i] = n_pred[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cost_q  <= '0;
      pred_q  <= '0;
      valid_q <= 1'b0;
      odd_q   <= 1'b0;
      col_q   <= '0;
    end else begin
      cost_q  <= cost_d;
      pred_q  <= pred_d;
      valid_q <= calc_en && !line_start;
      if (calc_en) begin
        odd_q <= calc_odd;
        col_q <= col_now;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_odd   = odd_q;
  assign out_col   = col_q;
  assign out_cost  = cost_q;
  assign out_pred  = pred_q;

  AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_i)
    line_start |=> (out_cost == '0 && !out_valid)); // R11

  AST_PHASE_PAIR: assert property (@(posedge clk) disable iff (!rst_i)
    (out_valid && !out_odd && !line_start)
      |=> (out_valid && out_odd && (out_col == $past(out_col) + COL_W'(1)))); // R2

endmodule

// File: tb/cyc_dp_cost_bench.sv
module cyc_dp_cost_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DMAX   = 4;
  localparam int PIX_W  = 8;
  localparam int COST_W = 10;
  localparam int POS_W  = 12;
  localparam int LANES  = DMAX + 1;
  localparam int CMAX   = (1 << COST_W) - 1;

  logic clk = 1'b0;
  logic rst_n, line_start, pix_valid;
  logic [PIX_W-1:0]  pix_l, pix_r;
  logic [COST_W-1:0] occ_pen;
  logic              out_valid, out_odd;
  logic [POS_W:0]    out_col;
  logic [LANES*3*2-1:0]      out_pred;
  logic [LANES*3*COST_W-1:0] out_cost;

  always #(CLK_PERIOD/2) clk = ~clk;

  cyc_dp_cost #(.DMAX(DMAX), .PIX_W(PIX_W), .COST_W(COST_W), .POS_W(POS_W)) u_cyc_dp_cost (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .pix_valid(pix_valid),
    .pix_l(pix_l), .pix_r(pix_r), .occ_pen(occ_pen),
    .out_valid(out_valid), .out_odd(out_odd), .out_col(out_col),
    .out_pred(out_pred), .out_cost(out_cost)
  );

  int checks = 0;
  int errors = 0;
  int gl [0:63];
  int gr [0:63];
  int cm [0:2][0:127][0:DMAX];
  int pm [0:2][0:127][0:DMAX];
  int n_pix;
  int occ;
  int unsigned seed = 32'h1234_5678;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int cost_of(int d, int s);
    return int'(out_cost[(3*d+s)*COST_W +: COST_W]);
  endfunction

  function automatic int pred_of(int d, int s);
    return int'(out_pred[(3*d+s)*2 +: 2]);
  endfunction

  function automatic int mget(int s, int x, int d);
    if (d < 0 || d > DMAX) return CMAX;
    if (x < 0) return 0;
    return cm[s][x][d];
  endfunction

  function automatic int sat(int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  function automatic int next_pix();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'hFF);
  endfunction

  // Reference: full column-by-disparity table, states 0=MR 1=B 2=ML
  task automatic model_col(input int x);
    for (int d = x % 2; d <= DMAX; d += 2) begin
      int best, code, df;
      if (x < d) begin
        cm[1][x][d] = CMAX; pm[1][x][d] = 3;
      end else begin
        best = mget(1, x-2, d); code = 1;
        if (mget(0, x-2, d) < best)   begin best = mget(0, x-2, d);   code = 0; end
        if (mget(2, x-1, d-1) < best) begin best = mget(2, x-1, d-1); code = 2; end
        df = gl[(x+d)/2] - gr[(x-d)/2];
        if (df < 0) df = -df;
        cm[1][x][d] = sat(best + df); pm[1][x][d] = code;
      end
      best = mget(1, x-2, d); code = 1;
      if (mget(2, x-1, d-1) < best) begin best = mget(2, x-1, d-1); code = 2; end
      cm[2][x][d] = sat(best + occ); pm[2][x][d] = code;
      best = mget(1, x-1, d+1); code = 1;
      if (mget(0, x-1, d+1) < best) begin best = mget(0, x-1, d+1); code = 0; end
      cm[0][x][d] = sat(best + occ); pm[0][x][d] = code;
    end
  endtask

  task automatic check_column(input int x);
    chk("R2", "out_valid", int'(out_valid), 1);
    chk("R2", "out_col", int'(out_col), x);
    chk("R2", "out_odd", int'(out_odd), x % 2);
    for (int d = 0; d <= DMAX; d++) begin
      if ((d % 2) == (x % 2)) begin
        chk("R3", $sformatf("x%0d d%0d B cost", x, d), cost_of(d, 1), cm[1][x][d]);
        chk("R4", $sformatf("x%0d d%0d ML cost", x, d), cost_of(d, 2), cm[2][x][d]);
        chk("R5", $sformatf("x%0d d%0d MR cost", x, d), cost_of(d, 0), cm[0][x][d]);
        for (int s = 0; s < 3; s++)
          chk("R9", $sformatf("x%0d d%0d s%0d pred", x, d, s), pred_of(d, s), pm[s][x][d]);
        if (x < d) chk("R6", $sformatf("x%0d d%0d blocked code", x, d), pred_of(d, 1), 3);
      end else begin
        for (int s = 0; s < 3; s++)
          chk("R10", $sformatf("x%0d d%0d s%0d held", x, d, s), cost_of(d, s), mget(s, x-1, d));
      end
    end
  endtask

  // Starts and ends just after a falling edge
  task automatic push(input int l, input int r);
    int k;
    k = n_pix;
    gl[k] = l; gr[k] = r;
    n_pix++;
    pix_valid = 1'b1; pix_l = PIX_W'(l); pix_r = PIX_W'(r);
    @(negedge clk);
    pix_valid = 1'b0;
    @(negedge clk);
    if (k >= DMAX/2) begin
      model_col(2*k - DMAX);
      check_column(2*k - DMAX);
      @(negedge clk);
      model_col(2*k - DMAX + 1);
      check_column(2*k - DMAX + 1);
    end else begin
      chk("R12", "no result, first phase", int'(out_valid), 0);
      @(negedge clk);
      chk("R12", "no result, second phase", int'(out_valid), 0);
    end
  endtask

  task automatic start_line(input int penalty);
    occ = penalty;
    occ_pen = COST_W'(penalty);
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    n_pix = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; line_start = 1'b0; pix_valid = 1'b0;
    pix_l = '0; pix_r = '0; occ_pen = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "out_valid after reset", int'(out_valid), 0);
    chk("R1", "out_cost zero after reset", int'(out_cost == '0), 1);
    chk("R1", "out_pred zero after reset", int'(out_pred == '0), 1);
  endtask

  task automatic t_random_line();
    start_line(6);
    for (int i = 0; i < 14; i++) push(next_pix(), next_pix());
  endtask

  task automatic t_flat_ties();
    start_line(3);
    for (int i = 0; i < 3; i++) push(100, 100);
    // Column 1 is on the outputs; lane 0 still shows column 0
    chk("R8", "x0 d0 B tie B/MR picks B", pred_of(0, 1), 1);
    chk("R8", "x0 d0 MR tie picks B", pred_of(0, 0), 1);
    chk("R8", "x1 d1 B tie B/MR picks B", pred_of(1, 1), 1);
    chk("R6", "x0 d2 binocular blocked cost", cost_of(2, 1), CMAX);
    for (int i = 0; i < 5; i++) push(100, 100);
  endtask

  task automatic t_saturation();
    start_line(1000);
    for (int i = 0; i < 4; i++) push(255, 0);
    // Outputs show column 3; lane 0 holds column 2 ML = min(inf, 255)+1000
    chk("R7", "x2 d0 ML saturates", cost_of(0, 2), CMAX);
    for (int i = 0; i < 3; i++) push(255, 0);
  endtask

  task automatic t_restart();
    start_line(9);
    for (int i = 0; i < 5; i++) push(next_pix(), next_pix());
    start_line(20);
    chk("R11", "costs zero after line_start", int'(out_cost == '0), 1);
    chk("R11", "no result after line_start", int'(out_valid), 0);
    // Step edge shifted by two pixels between views
    for (int i = 0; i < 12; i++) push((i < 6) ? 30 : 200, (i < 4) ? 30 : 200);
    chk("R11", "column index restarted", int'(out_col), 2*11 - DMAX + 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    n_pix = 0; occ = 0;
    @(negedge clk);
    t_reset();
    t_random_line();
    t_flat_ties();
    t_saturation();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule